// File: doc/BRIEF.md
# PLL Control and Status Register Block

This block holds the software-visible settings for a clock-generator PLL and turns the PLL's lock indication into an interrupt. The registers sit on a simple synchronous register bus with address, write enable, read enable, write data and read data. The block drives the VCO multiplier and range codes, the PLL enable and the base-clock-select control to the analog side and to the clock multiplexer. Those circuits are outside the block.

The frequency settings are protected. While the PLL is enabled, writes to the multiplier and range codes are dropped. A range code of zero forces the PLL off and keeps the base clock on its reference source. The block brings the asynchronous lock input into the register clock domain. When automatic mode is on, every change of the lock input raises a sticky flag. The flag is gated by an enable to form the interrupt request, and a read of the control register clears it.

Registers: CTRL at address 0 and FREQ at address 1. The read data bus carries the selected register at all times; the read enable only triggers the flag clear.

Top module: `pll_ctrl_regs`

## Requirements
- R1: After reset, CTRL reads 0x00 while the lock input is low, FREQ reads 0x61 (range 6, multiplier 1), and `pll_on_o`, `clk_sel_o` and `irq_o` are 0.
- R2: The multiplier code is FREQ bits [3:0]. Its value N is used directly as the multiplier, for example 13 gives 13 and 15 gives 15. A FREQ write while the PLL enable bit is 1 leaves the multiplier unchanged.
- R3: The VCO range code is FREQ bits [7:4]. A FREQ write while the PLL enable bit is 1 leaves the range code unchanged.
- R4: While the range code is 0, the PLL enable (CTRL bit 0) and the base-clock-select (CTRL bit 1) read 0 and their outputs are 0. A write that tries to set either bit is refused. Writing range 0 clears a base-clock-select that was set.
- R5: With a nonzero range code, the base-clock-select bit can be set while the lock input is 0.
- R6: With the automatic-mode bit (CTRL bit 4) at 1, every change of the lock input, rising or falling, sets the interrupt flag (CTRL bit 3) within four clock cycles.
- R7: The flag is set whether or not the interrupt enable (CTRL bit 2) is 1. `irq_o` equals the flag ANDed with the interrupt enable.
- R8: While the automatic-mode bit is 0, the flag reads 0, lock changes set nothing, and `irq_o` stays 0.
- R9: A read of CTRL (rd_en with address 0) clears the flag. If a lock change is detected in the same cycle as that read, the flag stays set.
- R10: CTRL bit 5 reads the synchronized lock level. Bits 3 and 5 are read-only, so writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (clears the flag on a CTRL read) |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data of the addressed register |
| lock_i | input | 1 | Asynchronous lock indication from the PLL |
| pll_on_o | output | 1 | PLL enable |
| clk_sel_o | output | 1 | Base-clock-select control |
| mult_o | output | 4 | VCO multiplier code |
| range_o | output | 4 | VCO range code |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a lock change that the edge detector sees in exactly the cycle where software reads CTRL. The read would clear the flag and the edge sets it, and the set must win. The bench counts the register stages between a change on `lock_i` and the internal edge pulse. It changes the lock input, waits through the two synchronizer edges, and presents the CTRL read in the third cycle. It then checks that `irq_o` stays high. A second hard case is a range code of zero while base-clock-select is set. To reach it, the bench sets the select bit with the PLL off and then writes range 0.

// File: rtl/pllc_pkg.sv
package pllc_pkg;

    localparam int FLD_W = 4;

    // CTRL bit positions
    localparam int B_PLL_ON  = 0;
    localparam int B_CLK_SEL = 1;
    localparam int B_IRQ_EN  = 2;
    localparam int B_FLAG    = 3;
    localparam int B_AUTO    = 4;
    localparam int B_LOCK    = 5;

    typedef struct packed {
        logic             pll_on;
        logic             clk_sel;
        logic             irq_en;
        logic             flag;
        logic             auto_mode;
        logic [FLD_W-1:0] mult;
        logic [FLD_W-1:0] range;
    } pllc_state_t;

endpackage

// File: rtl/pllc_sync.sv
module pllc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pllc_edge.sv
module pllc_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic toggle_o
);
    logic prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= lvl_i;
    end

    assign toggle_o = lvl_i ^ prev_q;
endmodule

// File: rtl/pll_ctrl_regs.sv
module pll_ctrl_regs
    import pllc_pkg::*;
#(
    parameter int               ADDR_W      = 4,
    parameter int               DATA_W      = 8,
    parameter int               SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 0,
    parameter logic [ADDR_W-1:0] FREQ_ADDR  = 1,
    parameter logic [FLD_W-1:0] MULT_RST    = 4'd1,
    parameter logic [FLD_W-1:0] RANGE_RST   = 4'd6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              lock_i,
    output logic              pll_on_o,
    output logic              clk_sel_o,
    output logic [FLD_W-1:0]  mult_o,
    output logic [FLD_W-1:0]  range_o,
    output logic              irq_o
);
    localparam int FREQ_W = 2 * FLD_W;

    pllc_state_t st_d, st_q;
    logic        lock_sync;
    logic        lock_toggle;
    logic        wr_ctrl, wr_freq, rd_ctrl;

    pllc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (lock_i),
        .q_o    (lock_sync)
    );

    pllc_edge u_edge (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .lvl_i    (lock_sync),
        .toggle_o (lock_toggle)
    );

    assign wr_ctrl = wr_en_i && (addr_i == CTRL_ADDR);
    assign wr_freq = wr_en_i && (addr_i == FREQ_ADDR);
    assign rd_ctrl = rd_en_i && (addr_i == CTRL_ADDR);

    always_comb begin
        st_d = st_q;
        if (wr_freq && !st_q.pll_on) begin
            st_d.mult  = wdata_i[FLD_W-1:0];
            st_d.range = wdata_i[FREQ_W-1:FLD_W];
        end
        if (wr_ctrl) begin
            st_d.pll_on    = wdata_i[B_PLL_ON];
            st_d.clk_sel   = wdata_i[B_CLK_SEL];
            st_d.irq_en    = wdata_i[B_IRQ_EN];
            st_d.auto_mode = wdata_i[B_AUTO];
        end
        // zero range code disables the PLL and pins the clock source
        if (st_d.range == '0) begin
            st_d.pll_on  = 1'b0;
            st_d.clk_sel = 1'b0;
        end
        // read clears, a detected lock change in the same cycle wins
        if (rd_ctrl)                           st_d.flag = 1'b0;
        if (st_q.auto_mode && lock_toggle)     st_d.flag = 1'b1;
        if (!st_d.auto_mode)                   st_d.flag = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{pll_on: 1'b0, clk_sel: 1'b0, irq_en: 1'b0, flag: 1'b0,
                      auto_mode: 1'b0, mult: MULT_RST, range: RANGE_RST};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == CTRL_ADDR) begin
            rdata_o[B_PLL_ON]  = st_q.pll_on;
            rdata_o[B_CLK_SEL] = st_q.clk_sel;
            rdata_o[B_IRQ_EN]  = st_q.irq_en;
            rdata_o[B_FLAG]    = st_q.flag;
            rdata_o[B_AUTO]    = st_q.auto_mode;
            rdata_o[B_LOCK]    = lock_sync;
        end else if (addr_i == FREQ_ADDR) begin
            rdata_o[FREQ_W-1:0] = {st_q.range, st_q.mult};
        end
    end

    assign pll_on_o  = st_q.pll_on;
    assign clk_sel_o = st_q.clk_sel;
    assign mult_o    = st_q.mult;
    assign range_o   = st_q.range;
    assign irq_o     = st_q.flag & st_q.irq_en;
endmodule

// File: rtl/pll_ctrl_regs_chk.sv
module pll_ctrl_regs_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 0,
    parameter logic [ADDR_W-1:0] FREQ_ADDR = 1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              pll_on_o,
    input logic              clk_sel_o,
    input logic [3:0]        mult_o,
    input logic [3:0]        range_o,
    input logic              irq_o
);
    // R2
    mult_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pll_on_o && wr_en_i && addr_i == FREQ_ADDR) |=> $stable(mult_o));

    // R3
    range_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pll_on_o && wr_en_i && addr_i == FREQ_ADDR) |=> $stable(range_o));

    // R4
    zero_range_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (range_o == 4'd0) |-> (!pll_on_o && !clk_sel_o));

    // R7
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == CTRL_ADDR) |-> (irq_o == (rdata_o[3] && rdata_o[2])));

    // R8
    manual_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == CTRL_ADDR && !rdata_o[4]) |-> (!rdata_o[3] && !irq_o));
endmodule

bind pll_ctrl_regs pll_ctrl_regs_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .FREQ_ADDR(FREQ_ADDR)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .rdata_o   (rdata_o),
    .pll_on_o  (pll_on_o),
    .clk_sel_o (clk_sel_o),
    .mult_o    (mult_o),
    .range_o   (range_o),
    .irq_o     (irq_o)
);

// File: tb/pll_ctrl_regs_bench.sv
`timescale 1ns/1ps
module pll_ctrl_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       lock = 1'b0;
    logic       pll_on, clk_sel, irq;
    logic [3:0] mult, range;
    int         checks = 0;
    int         fails = 0;

    always #4 clk = ~clk;

    pll_ctrl_regs u_pll_ctrl_regs (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
        .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata), .lock_i(lock),
        .pll_on_o(pll_on), .clk_sel_o(clk_sel), .mult_o(mult),
        .range_o(range), .irq_o(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = (a == 4'd0);
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_lock(input logic v);
        @(negedge clk);
        lock = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] r;
        bus_rd(4'd0, r); check("R1 ctrl", r, 8'h00);
        bus_rd(4'd1, r); check("R1 freq", r, 8'h61);
        check("R1 pll_on", pll_on, 0);
        check("R1 clk_sel", clk_sel, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_freq_protect;
        logic [7:0] r;
        bus_wr(4'd1, 8'h3D);
        check("R2 mult 13", mult, 13);
        check("R3 range 3", range, 3);
        bus_wr(4'd0, 8'h01);
        check("R2 pll on", pll_on, 1);
        bus_wr(4'd1, 8'h5F);
        check("R2 mult kept", mult, 13);
        check("R3 range kept", range, 3);
        bus_rd(4'd1, r); check("R3 freq kept", r, 8'h3D);
        bus_wr(4'd0, 8'h00);
        bus_wr(4'd1, 8'h6F);
        check("R2 mult 15", mult, 15);
    endtask

    task automatic t_range_zero;
        logic [7:0] r;
        bus_wr(4'd0, 8'h02);
        check("R5 clk_sel without lock", clk_sel, 1);
        bus_wr(4'd1, 8'h0F);
        check("R4 clk_sel cleared", clk_sel, 0);
        bus_wr(4'd0, 8'h03);
        check("R4 pll_on refused", pll_on, 0);
        check("R4 clk_sel refused", clk_sel, 0);
        bus_rd(4'd0, r); check("R4 ctrl read", r, 8'h00);
        bus_wr(4'd1, 8'h6F);
        bus_wr(4'd0, 8'h00);
    endtask

    task automatic t_auto_irq;
        logic [7:0] r;
        bus_wr(4'd0, 8'h10);
        set_lock(1'b1);
        check("R7 irq gated off", irq, 0);
        bus_rd(4'd0, r); check("R6 rise flag", r, 8'h38);
        bus_rd(4'd0, r); check("R9 read clears", r, 8'h30);
        bus_wr(4'd0, 8'h14);
        set_lock(1'b0);
        check("R6 R7 fall irq", irq, 1);
        bus_rd(4'd0, r); check("R6 fall flag", r, 8'h1C);
        check("R9 irq after read", irq, 0);
    endtask

    task automatic t_manual;
        logic [7:0] r;
        bus_wr(4'd0, 8'h04);
        set_lock(1'b1);
        check("R8 irq", irq, 0);
        bus_rd(4'd0, r); check("R8 flag reads 0", r, 8'h24);
        bus_wr(4'd0, 8'h14);
        check("R8 no stale flag", irq, 0);
        set_lock(1'b0);
        check("R8 auto again", irq, 1);
        bus_rd(4'd0, r);
    endtask

    task automatic t_read_race;
        logic [7:0] r;
        @(negedge clk); lock = 1'b1;
        @(negedge clk);
        @(negedge clk);
        addr = 4'd0; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R9 edge beats clear", irq, 1);
        bus_rd(4'd0, r); check("R9 flag after race", r, 8'h3C);
        check("R9 cleared later", irq, 0);
    endtask

    task automatic t_readonly;
        logic [7:0] r;
        bus_wr(4'd0, 8'h38);
        bus_rd(4'd0, r); check("R10 ro bits", r, 8'h30);
        set_lock(1'b0);
        bus_rd(4'd0, r); check("R10 lock level", r, 8'h18);
        bus_rd(4'd0, r); check("R10 lock low", r, 8'h10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_freq_protect();
        t_range_zero();
        t_auto_irq();
        t_manual();
        t_read_race();
        t_readonly();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule